// File: doc/BRIEF.md
# Audio Serial Clock Master Generator

This block produces the two clocks of an audio serial port that acts as clock master: a bit clock and a frame (left/right) clock. Both are derived from the master clock that also clocks the block. Two controls pick the divide ratio. The first selects single or double speed. The second is a 3-bit code that gives the ratio of the master clock to the sample rate. Whatever the ratio, the frame clock runs at the sample rate and the bit clock at 64 times the sample rate.

Besides the two registered clocks, the block gives a serializer two one-cycle strobes. One marks the cycle in which the bit clock falls and the other marks the start of a frame. A new speed or ratio selection takes effect only at a frame boundary, so a running frame is never cut short or stretched. The error flag is raised, and no clocks are produced, when the ratio code is not a supported one or when a time-division multiplexed format is requested, since that format is not available to a clock master.

Top module: `acg_master_clkgen`

## Requirements
- R1: After a synchronous reset, all outputs are low: bit clock, frame clock, both strobes and the error flag.
- R2: The number of master clock cycles per bit clock period follows the ratio code. In single speed (`dbl_speed_i`=0), code 000 gives 4, code 001 gives 6 and code 010 gives 8. In double speed (`dbl_speed_i`=1) the same codes give 2, 3 and 4. A frame is 64 bit clock periods long.
- R3: Each bit clock period starts low for ceil(N/2) master cycles and is then high for floor(N/2) master cycles, where N is the period length.
- R4: The frame clock is low for the first 32 bit clock periods of a frame and high for the last 32. It changes only in a cycle that carries the falling-edge strobe.
- R5: `sclk_fall_o` is high for exactly one cycle at the first cycle of every bit clock period, which is the cycle in which the bit clock goes low.
- R6: `frame_start_o` is high for exactly one cycle at the first cycle of each frame. In that cycle the frame clock is low.
- R7: Ratio codes 011 to 111 are invalid. While an invalid code is in effect, the bit clock and frame clock stay low and `cfg_err_o` is high.
- R8: While `tdm_req_i` is high and in effect, `cfg_err_o` is high and no clocks or strobes are produced.
- R9: A change to the speed or ratio code made during a running frame does not alter that frame. It is adopted at the next frame boundary.
- R10: When `en_i` goes low, all clock and strobe outputs are low from the next cycle on. When enabling starts from idle, the first output cycle is a frame start: both strobes are high and the frame clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables clock generation |
| dbl_speed_i | input | 1 | 0 selects single speed, 1 selects double speed |
| rate_sel_i | input | 3 | Master-clock-to-sample-rate ratio code |
| tdm_req_i | input | 1 | Request for the time-division multiplexed format (not allowed) |
| sclk_o | output | 1 | Registered bit clock, 64 times the sample rate |
| lrck_o | output | 1 | Registered frame clock at the sample rate |
| sclk_fall_o | output | 1 | One-cycle strobe at each bit clock falling edge |
| frame_start_o | output | 1 | One-cycle strobe at the first cycle of each frame |
| cfg_err_o | output | 1 | High while an invalid ratio code or a format request is in effect |

## Verification
Each of the six valid speed and ratio pairs is run from a clean start, and the frame length and the number of falling strobes per frame are measured. These runs separate the even and odd period lengths and the duty split between them. A directed run changes the ratio in the middle of a frame, which shows whether the change waits for the frame boundary. Invalid codes and format requests are applied from idle to check that the error path gives silent outputs. A long seeded random stretch mixes configuration changes, enable toggles and resets, and every output is compared in every cycle against a frame-position model. This exposes phase errors around restarts and boundaries.

// File: rtl/acg_pkg.sv
package acg_pkg;

    localparam int CNT_W       = 4;            // holds the longest bit clock period
    localparam int SLOTS_LOG2  = 6;            // 64 bit clock periods per frame
    localparam int LAST_VALID  = 2;            // highest supported ratio code

    typedef struct packed {
        logic       dbl;
        logic [2:0] rate;
        logic       tdm;
    } acg_cfg_t;

    function automatic logic cfg_ok(acg_cfg_t c);
        return (c.rate <= 3'(LAST_VALID)) && !c.tdm;
    endfunction

    // master clock cycles per bit clock period
    function automatic logic [CNT_W-1:0] sclk_div(acg_cfg_t c);
        logic [CNT_W-1:0] base;
        case (c.rate)
            3'd0:    base = CNT_W'(4);
            3'd1:    base = CNT_W'(6);
            default: base = CNT_W'(8);
        endcase
        return c.dbl ? (base >> 1) : base;
    endfunction

    // cycles spent low at the start of a period: ceil(n/2)
    function automatic logic [CNT_W-1:0] low_len(logic [CNT_W-1:0] n);
        logic [CNT_W:0] w;
        w = ({1'b0, n} + (CNT_W+1)'(1)) >> 1;
        return w[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/acg_sclk_timer.sv
module acg_sclk_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic         load_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] cnt_d,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;

    assign tick_o = (cnt_q == period_i - W'(1));

    always_comb begin
        if (!go_i || load_i || tick_o) cnt_d = '0;
        else                           cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        cnt_q < period_i) else $error("cycle count beyond period"); // R2

endmodule

// File: rtl/acg_frame_ctr.sv
module acg_frame_ctr #(
    parameter int BW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  logic          load_i,
    input  logic          tick_i,
    output logic [BW-1:0] slot_d,
    output logic          last_o
);
    logic [BW-1:0] slot_q;

    assign last_o = &slot_q;

    always_comb begin
        if (!go_i || load_i) slot_d = '0;
        else if (tick_i)     slot_d = slot_q + BW'(1);
        else                 slot_d = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (go_i && !load_i && !tick_i) |=> $stable(slot_q)) else $error("slot moved mid period"); // R4

endmodule

// File: rtl/acg_master_clkgen.sv
module acg_master_clkgen
    import acg_pkg::*;
(
    input  logic       mclk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       dbl_speed_i,
    input  logic [2:0] rate_sel_i,
    input  logic       tdm_req_i,
    output logic       sclk_o,
    output logic       lrck_o,
    output logic       sclk_fall_o,
    output logic       frame_start_o,
    output logic       cfg_err_o
);
    acg_cfg_t cfg_in, cfg_q, cfg_use;
    logic     active_q, boundary, run, tick, last;
    logic [CNT_W-1:0]      cnt_d;
    logic [SLOTS_LOG2-1:0] slot_d;

    always_comb begin
        cfg_in.dbl  = dbl_speed_i;
        cfg_in.rate = rate_sel_i;
        cfg_in.tdm  = tdm_req_i;
    end

    assign boundary = !active_q || (tick && last);
    assign cfg_use  = boundary ? cfg_in : cfg_q;
    assign run      = en_i && cfg_ok(cfg_use);

    acg_sclk_timer #(.W(CNT_W)) u_timer (
        .clk      (mclk_i),
        .rst      (rst_i),
        .go_i     (run),
        .load_i   (boundary),
        .period_i (sclk_div(cfg_q)),
        .cnt_d    (cnt_d),
        .tick_o   (tick)
    );

    acg_frame_ctr #(.BW(SLOTS_LOG2)) u_frame (
        .clk    (mclk_i),
        .rst    (rst_i),
        .go_i   (run),
        .load_i (boundary),
        .tick_i (tick),
        .slot_d (slot_d),
        .last_o (last)
    );

    always_ff @(posedge mclk_i) begin
        if (rst_i) begin
            cfg_q         <= '0;
            active_q      <= 1'b0;
            sclk_o        <= 1'b0;
            lrck_o        <= 1'b0;
            sclk_fall_o   <= 1'b0;
            frame_start_o <= 1'b0;
            cfg_err_o     <= 1'b0;
        end else begin
            cfg_q         <= cfg_use;
            active_q      <= run;
            cfg_err_o     <= !cfg_ok(cfg_use);
            sclk_o        <= run && (cnt_d >= low_len(sclk_div(cfg_use)));
            lrck_o        <= run && slot_d[SLOTS_LOG2-1];
            sclk_fall_o   <= run && (cnt_d == '0);
            frame_start_o <= run && (cnt_d == '0) && (slot_d == '0);
        end
    end

    AST_FALL_STROBED: assert property (@(posedge mclk_i) disable iff (rst_i)
        (active_q && $fell(sclk_o)) |-> sclk_fall_o) else $error("unmarked fall"); // R5
    AST_FALL_LOW: assert property (@(posedge mclk_i) disable iff (rst_i)
        sclk_fall_o |-> !sclk_o) else $error("strobe with clock high"); // R3
    AST_LRCK_ON_FALL: assert property (@(posedge mclk_i) disable iff (rst_i)
        (active_q && !$stable(lrck_o)) |-> sclk_fall_o) else $error("frame clock off edge"); // R4
    AST_FRAME_LRCK_LOW: assert property (@(posedge mclk_i) disable iff (rst_i)
        frame_start_o |-> (!lrck_o && sclk_fall_o)) else $error("frame start phase"); // R6
    AST_ERR_QUIET: assert property (@(posedge mclk_i) disable iff (rst_i)
        cfg_err_o |-> (!sclk_o && !lrck_o && !sclk_fall_o)) else $error("clocks during error"); // R7
    AST_CFG_HOLD: assert property (@(posedge mclk_i) disable iff (rst_i)
        (active_q && !frame_start_o) |-> $stable(cfg_q)) else $error("config changed mid frame"); // R9

endmodule

// File: tb/tb_acg_master_clkgen.sv
`timescale 1ns/1ps
module tb_acg_master_clkgen;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, en, dbl, tdm;
    logic [2:0] rate;
    logic sclk, lrck, fall, fstart, err;

    acg_master_clkgen dut (
        .mclk_i(clk), .rst_i(rst), .en_i(en), .dbl_speed_i(dbl), .rate_sel_i(rate),
        .tdm_req_i(tdm), .sclk_o(sclk), .lrck_o(lrck), .sclk_fall_o(fall),
        .frame_start_o(fstart), .cfg_err_o(err)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    bit m_run = 0; int m_t = 0, m_n = 4, m_dbl = 0, m_rate = 0, m_tdm = 0;
    int e_sclk = 0, e_lrck = 0, e_fall = 0, e_frame = 0, e_err = 0;

    function automatic int ref_div(int d, int r);
        int ratio;
        case (r)
            0: ratio = 256;
            1: ratio = 384;
            default: ratio = 512;
        endcase
        if (d != 0) ratio = ratio / 2;
        return ratio / 64;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit bnd, ok;
        if (rst) begin
            m_run = 0; m_t = 0; m_dbl = 0; m_rate = 0; m_tdm = 0;
            e_sclk = 0; e_lrck = 0; e_fall = 0; e_frame = 0; e_err = 0;
        end else begin
            bnd = !m_run || (m_t == 64 * m_n - 1);
            if (bnd) begin m_dbl = int'(dbl); m_rate = int'(rate); m_tdm = int'(tdm); end
            ok = (m_rate <= 2) && (m_tdm == 0);
            e_err = ok ? 0 : 1;
            if (!(en && ok)) begin
                m_run = 0; m_t = 0;
                e_sclk = 0; e_lrck = 0; e_fall = 0; e_frame = 0;
            end else begin
                if (bnd) begin m_run = 1; m_t = 0; m_n = ref_div(m_dbl, m_rate); end
                else m_t++;
                e_sclk  = ((m_t % m_n) >= (m_n + 1) / 2) ? 1 : 0;
                e_lrck  = ((m_t / m_n) >= 32) ? 1 : 0;
                e_fall  = ((m_t % m_n) == 0) ? 1 : 0;
                e_frame = (m_t == 0) ? 1 : 0;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R3 sclk", int'(sclk), e_sclk);
        chk("R4 lrck", int'(lrck), e_lrck);
        chk("R5 fall strobe", int'(fall), e_fall);
        chk("R6 frame strobe", int'(fstart), e_frame);
        chk("R7 err flag", int'(err), e_err);
    endtask

    task automatic restart(bit d, logic [2:0] r);
        rst = 1; en = 0; step();
        rst = 0; dbl = d; rate = r; tdm = 0; en = 1;
        for (int i = 0; i < 4 && !fstart; i++) step();
    endtask

    task automatic frame_len(output int len, output int falls);
        len = 0; falls = 0;
        do begin
            step(); len++;
            if (fall) falls++;
        end while (!fstart && len < 2000);
    endtask

    initial begin
        int len, falls;
        void'($urandom(32'd4242));
        rst = 1; en = 0; dbl = 0; rate = 0; tdm = 0;
        @(negedge clk);
        repeat (3) step();
        // R1 reset state
        chk("R1 reset sclk", int'(sclk), 0);
        chk("R1 reset lrck", int'(lrck), 0);
        chk("R1 reset strobes", int'(fall | fstart), 0);
        chk("R1 reset err", int'(err), 0);

        // R2 every valid pair
        for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < 3; r++) begin
                restart(d[0], r[2:0]);
                chk("R2 first frame start", int'(fstart), 1);
                frame_len(len, falls);
                chk("R2 frame length", len, 64 * ref_div(d, r));
                chk("R2 periods per frame", falls, 64);
            end
        end

        // R9 mid-frame change waits for boundary
        restart(1'b0, 3'd2);
        repeat (100) step();
        rate = 3'd0;
        frame_len(len, falls);
        chk("R9 current frame kept", len + 100, 512);
        frame_len(len, falls);
        chk("R9 new ratio at boundary", len, 256);

        // R10 disable and restart
        repeat (37) step();
        en = 0; step();
        chk("R10 off sclk/lrck", int'(sclk | lrck), 0);
        chk("R10 off strobes", int'(fall | fstart), 0);
        en = 1; step();
        chk("R10 restart frame", int'(fstart), 1);
        chk("R10 restart fall", int'(fall), 1);
        chk("R10 restart lrck", int'(lrck), 0);

        // R7 invalid codes
        for (int r = 3; r < 8; r++) begin
            en = 0; step();
            rate = r[2:0]; en = 1;
            len = 0;
            for (int i = 0; i < 40; i++) begin step(); len += int'(sclk | lrck); end
            chk("R7 invalid err", int'(err), 1);
            chk("R7 invalid silent", len, 0);
        end

        // R8 format request
        en = 0; rate = 3'd1; step();
        tdm = 1; en = 1;
        len = 0;
        for (int i = 0; i < 60; i++) begin step(); len += int'(sclk | lrck | fall | fstart); end
        chk("R8 tdm err", int'(err), 1);
        chk("R8 tdm silent", len, 0);
        tdm = 0;

        // random mix
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(199) == 0) begin
                dbl  = 1'($urandom_range(1));
                rate = ($urandom_range(3) == 3) ? 3'($urandom_range(7)) : 3'($urandom_range(2));
                tdm  = ($urandom_range(9) == 0);
            end
            if ($urandom_range(299) == 0) en = ~en;
            rst = ($urandom_range(999) == 0);
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule